// File: doc/BRIEF.md
# Tick and Pulse Timer

This block is a small timer core with two counting sources. In tick mode its 16-bit counter advances on every clock cycle while it runs. In pulse mode the counter advances on qualifying edges of one of four external pulse pins. A select field picks the pin, and a polarity bit picks rising or falling edges. Each pin first crosses a two-stage synchronizer.

The counter is compared with a programmable compare value. When the counter advances while equal to that value, a sticky hit flag sets. The counter then restarts from zero, or, in free-running mode, keeps going and wraps only at overflow. The flag drives an interrupt line through an enable bit.

Software reaches three registers over a plain write strobe / address / data bus with combinational read data. Clearing the run bit resets the counter and the flag. Mode, restart, polarity and select bits are frozen while the timer runs.

Top module: `tpt_core`

## Requirements
- R1: After reset, control (address 0), compare (address 1) and counter (address 2) all read 0, and irq is 0.
- R2: While the run bit (control bit 0) is 0, the counter and the hit flag are held at 0. Writing the run bit to 0 clears both by the following clock edge.
- R3: In tick mode (control bit 1 = 0), the counter increases by one on every clock edge after the edge that set the run bit.
- R4: When the counter advances while equal to the compare value, the hit flag (control bit 7) is 1 after that edge. With control bit 2 = 0, the counter is 0 after that same edge, so a tick-mode period is compare+1 cycles.
- R5: With control bit 2 = 1, the counter runs past the compare value and wraps from 0xFFFF to 0. The hit flag still sets on the match.
- R6: In pulse mode (control bit 1 = 1) with polarity bit 3 = 0, each rising edge on pulse_in[n] is counted exactly once, where n is the code in control bits 5:4 (00..11 select pins 0..3). Activity on the other pins has no effect. Edges are counted from the second cycle after enabling.
- R7: With polarity bit 3 = 1, the counter counts falling edges of the selected pin instead.
- R8: A control write made while the run bit is already 1 leaves bits 5:1 unchanged. The read-back and the counting behaviour keep the old settings.
- R9: Writing 1 to control bit 7 clears the hit flag, and writing 0 there leaves it. irq is 1 exactly when the flag and the interrupt enable (control bit 6) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 compare, 2 counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pulse_in | input | 4 | External pulse pins, asynchronous |
| irq | output | 1 | Interrupt, hit flag gated by interrupt enable |

## Verification
The bench builds the block with its defaults: a 16-bit counter, four pulse pins and two synchronizer stages. The 16-bit width keeps a full counter wrap short enough to run once, so the overflow path of free-running mode gets checked directly. With four pins, random select codes reach every pin while the unselected pins carry noise. Random compare values from 0 upward cover the degenerate restart-every-cycle case as well as longer periods in both counting modes.

// File: rtl/tpt_pkg.sv
// Shared constants and types for the tick and pulse timer.
// Assumes a 2-bit register address space.
package tpt_pkg;
    localparam int unsigned ADDR_W = 2;

    // Register addresses on the bus
    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_CMP  = 2'd1,
        REG_CNT  = 2'd2
    } reg_addr_e;

    // Counting source
    typedef enum logic {
        MODE_TICK  = 1'b0,
        MODE_PULSE = 1'b1
    } count_mode_e;

    // Fixed control bit positions; the upper fields follow the select width
    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_MODE = 1;
    localparam int unsigned BIT_FREE = 2;
    localparam int unsigned BIT_POL  = 3;
    localparam int unsigned SEL_LO   = 4;
endpackage

// File: rtl/tpt_pulse_front.sv
// Pulse front end: synchronizes every external pin and picks one by select
// code. Detects the chosen edge polarity and emits a single-cycle event per edge.
// Assumes pins are asynchronous, pulses last at least two clock cycles,
// and sel/pol are changed only while run is low.
module tpt_pulse_front #(
    parameter int unsigned N_IN        = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SEL_W      = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  pins,
    input  logic [SEL_W-1:0] sel,
    input  logic             pol,
    input  logic             run,
    output logic             edge_evt
);
    logic [N_IN-1:0] sync_vec;
    logic            picked;
    logic            prev_q;
    logic            armed_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        // Shift one pin through its synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], pins[i]};
        end
        assign sync_vec[i] = chain_q[SYNC_STAGES-1];
    end

    assign picked = sync_vec[sel];

    // Remember the last picked level; arm one cycle after run so a select change is never seen as an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= picked;
            armed_q <= run;
        end
    end

    // Rising edge for pol=0, falling edge for pol=1
    always_comb begin
        if (pol) edge_evt = armed_q & prev_q & ~picked;
        else     edge_evt = armed_q & ~prev_q & picked;
    end
endmodule

// File: rtl/tpt_ctrl_regs.sv
// Control and compare registers. Bits 5:1 of control are writable only
// while the stored run bit is 0. Writing 1 to the flag position requests a
// flag clear. Assumes single-cycle write strobes.
module tpt_ctrl_regs
    import tpt_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned IRQEN_BIT = 6,
    parameter int unsigned FLAG_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic              run,
    output count_mode_e       mode,
    output logic              free,
    output logic              pol,
    output logic [SEL_W-1:0]  sel,
    output logic              irq_en,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag_clr
);
    logic ctrl_we;
    logic cmp_we;

    assign ctrl_we  = bus_wr && (bus_addr == REG_CTRL);
    assign cmp_we   = bus_wr && (bus_addr == REG_CMP);
    assign flag_clr = ctrl_we && bus_wdata[FLAG_BIT];

    // Control fields; configuration is locked by the run bit held before the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            mode   <= MODE_TICK;
            free   <= 1'b0;
            pol    <= 1'b0;
            sel    <= '0;
            irq_en <= 1'b0;
        end else if (ctrl_we) begin
            run    <= bus_wdata[BIT_RUN];
            irq_en <= bus_wdata[IRQEN_BIT];
            if (!run) begin
                mode <= count_mode_e'(bus_wdata[BIT_MODE]);
                free <= bus_wdata[BIT_FREE];
                pol  <= bus_wdata[BIT_POL];
                sel  <= bus_wdata[SEL_LO +: SEL_W];
            end
        end
    end

    // Compare value, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp <= '0;
        else if (cmp_we) cmp <= bus_wdata;
    end
endmodule

// File: rtl/tpt_counter.sv
// Counter and sticky hit flag. Advances on every cycle in tick mode or on
// edge events in pulse mode. Detects the match on an advance and restarts
// or continues according to the free-running bit. Held clear while not running.
module tpt_counter
    import tpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  count_mode_e      mode,
    input  logic             free,
    input  logic             edge_evt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic advance;
    logic hit;

    assign advance = (mode == MODE_PULSE) ? edge_evt : 1'b1;
    assign hit     = run && advance && (cnt == cmp);

    // Count value: cleared when idle, restarted on a match unless free-running
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (hit && !free) cnt <= '0;
        else if (advance)    cnt <= cnt + 1'b1;
    end

    // Sticky flag: a new match wins over a clear request in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (!run)     flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/tpt_core.sv
// Top of the tick and pulse timer: registers, pulse front end, counter,
// read-back mux and interrupt. Assumes bus_addr is stable while read data is used.
module tpt_core
    import tpt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned N_IN        = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [N_IN-1:0]   pulse_in,
    output logic              irq
);
    localparam int unsigned SEL_W     = $clog2(N_IN);
    localparam int unsigned IRQEN_BIT = SEL_LO + SEL_W;
    localparam int unsigned FLAG_BIT  = IRQEN_BIT + 1;

    logic             run_q;
    count_mode_e      mode_q;
    logic             free_q;
    logic             pol_q;
    logic [SEL_W-1:0] sel_q;
    logic             irq_en_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_clr;
    logic             edge_evt;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic [CNT_W-1:0] ctrl_rd;

    tpt_ctrl_regs #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .IRQEN_BIT(IRQEN_BIT), .FLAG_BIT(FLAG_BIT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .run(run_q), .mode(mode_q), .free(free_q),
        .pol(pol_q), .sel(sel_q), .irq_en(irq_en_q), .cmp(cmp_q),
        .flag_clr(flag_clr)
    );

    tpt_pulse_front #(
        .N_IN(N_IN), .SYNC_STAGES(SYNC_STAGES)
    ) i_front (
        .clk(clk), .rst_n(rst_n), .pins(pulse_in), .sel(sel_q), .pol(pol_q),
        .run(run_q), .edge_evt(edge_evt)
    );

    tpt_counter #(
        .CNT_W(CNT_W)
    ) i_count (
        .clk(clk), .rst_n(rst_n), .run(run_q), .mode(mode_q), .free(free_q),
        .edge_evt(edge_evt), .cmp(cmp_q), .flag_clr(flag_clr),
        .cnt(cnt_q), .flag(flag_q)
    );

    // Assemble the control word for read-back
    always_comb begin
        ctrl_rd                  = '0;
        ctrl_rd[BIT_RUN]         = run_q;
        ctrl_rd[BIT_MODE]        = mode_q;
        ctrl_rd[BIT_FREE]        = free_q;
        ctrl_rd[BIT_POL]         = pol_q;
        ctrl_rd[SEL_LO +: SEL_W] = sel_q;
        ctrl_rd[IRQEN_BIT]       = irq_en_q;
        ctrl_rd[FLAG_BIT]        = flag_q;
    end

    // Select read data by address
    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = ctrl_rd;
            REG_CMP:  bus_rdata = cmp_q;
            REG_CNT:  bus_rdata = cnt_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = flag_q & irq_en_q;
endmodule

// File: rtl/tpt_core_chk.sv
// Property checker for tpt_core, attached by bind. Observes the bus, the
// stored configuration, the counter and the hit flag.
module tpt_core_chk #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned FLAG_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              run,
    input logic              mode,
    input logic              free,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              flag
);
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0) && !flag);                                 // R2
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !mode && (free || cnt != cmp) |=> cnt == $past(cnt) + 1'b1); // R3
    AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        run && !mode && (cnt == cmp) |=> flag);                         // R4
    AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        run && !mode && !free && (cnt == cmp) |=> cnt == '0);           // R4
    AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        run && !mode && free && (cnt == cmp) |=> cnt == $past(cnt) + 1'b1); // R5
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        run && bus_wr && (bus_addr == '0) |=> mode == $past(mode) && free == $past(free)); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && flag && !(bus_wr && bus_addr == '0 && bus_wdata[FLAG_BIT]) |=> flag); // R9
endmodule

bind tpt_core tpt_core_chk #(
    .CNT_W(CNT_W), .ADDR_W(tpt_pkg::ADDR_W), .FLAG_BIT(FLAG_BIT)
) i_tpt_core_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .run(run_q), .mode(mode_q), .free(free_q),
    .cnt(cnt_q), .cmp(cmp_q), .flag(flag_q)
);

// File: tb/test_tpt_core.sv
`timescale 1ns/1ps
// Bench for tpt_core: seeded random tick and pulse runs plus directed corners.
module test_tpt_core;
    localparam int CNT_W = 16;
    localparam int N_IN  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic [N_IN-1:0]  pins = '0;
    logic             irq;
    int               checks = 0;
    int               errors = 0;

    always #2.5 clk = ~clk;

    tpt_core i_tpt_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pulse_in(pins), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [CNT_W-1:0] cword(input logic run, input logic mode, input logic free,
                                              input logic pol, input logic [1:0] sel,
                                              input logic ie, input logic clr);
        return {8'h00, clr, ie, sel, pol, free, mode, run};
    endfunction

    // Counter value after k advances
    function automatic int exp_cnt(input int k, input int c, input logic free);
        if (free) return k % (1 << CNT_W);
        return k % (c + 1);
    endfunction

    function automatic logic exp_flag(input int k, input int c);
        return k > c;
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [CNT_W-1:0] d;
        logic [CNT_W-1:0] a0;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 0);
        rd(2'd1, d); check("R1 cmp", d, 0);
        rd(2'd2, d); check("R1 cnt", d, 0);
        check("R1 irq", irq, 0);

        // R3 R4 R5 tick mode with random compare and duration, then R2 disable
        for (int it = 0; it < 8; it++) begin
            int c; int k; logic fr; logic ie;
            c  = (it == 0) ? 0 : 1 + $urandom % 40;
            k  = 1 + $urandom % 120;
            fr = $urandom % 2;
            ie = $urandom % 2;
            wr(2'd1, c[CNT_W-1:0]);
            wr(2'd0, cword(1, 0, fr, 0, 2'd0, ie, 0));
            repeat (k) @(negedge clk);
            rd(2'd2, d);
            check(fr ? "R5 R3 tick count" : "R4 R3 tick count", d, exp_cnt(k, c, fr));
            rd(2'd0, d);
            check("R4 hit flag", d[7], exp_flag(k, c));
            check("R9 irq", irq, exp_flag(k, c) & ie);
            wr(2'd0, cword(0, 0, fr, 0, 2'd0, ie, 0));
            @(negedge clk);
            rd(2'd2, d); check("R2 cnt cleared", d, 0);
            rd(2'd0, d); check("R2 flag cleared", d[7], 0);
        end

        // R9 flag clear semantics
        wr(2'd1, 16'd2);
        wr(2'd0, cword(1, 0, 1, 0, 2'd0, 1, 0));
        repeat (10) @(negedge clk);
        rd(2'd0, d); check("R9 flag set", d[7], 1);
        check("R9 irq on", irq, 1);
        wr(2'd0, cword(1, 0, 1, 0, 2'd0, 1, 0));
        rd(2'd0, d); check("R9 write 0 keeps flag", d[7], 1);
        wr(2'd0, cword(1, 0, 1, 0, 2'd0, 1, 1));
        rd(2'd0, d); check("R9 write 1 clears flag", d[7], 0);
        check("R9 irq off", irq, 0);

        // R8 configuration locked while running
        wr(2'd0, cword(1, 1, 0, 1, 2'd3, 1, 0));
        rd(2'd0, d); check("R8 ctrl readback", d & 16'h7F, 16'h45);
        rd(2'd2, a0);
        repeat (3) @(negedge clk);
        rd(2'd2, d); check("R8 still ticking", d - a0, 3);

        // R5 full wrap
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd5);
        wr(2'd0, cword(1, 0, 1, 0, 2'd0, 0, 0));
        repeat ((1 << CNT_W) + 3) @(negedge clk);
        rd(2'd2, d); check("R5 wrap count", d, 3);
        rd(2'd0, d); check("R5 flag after pass", d[7], 1);

        // R6 R7 pulse mode on random pins with noise on the others
        for (int it = 0; it < 10; it++) begin
            int s; int n; int c; logic p; logic fr;
            s  = $urandom % N_IN;
            p  = $urandom % 2;
            n  = 1 + $urandom % 12;
            fr = $urandom % 2;
            c  = fr ? 16'hFFFF : 1 + $urandom % 5;
            wr(2'd0, 16'h0000);
            pins = {N_IN{p}};
            repeat (4) @(negedge clk);
            wr(2'd1, c[CNT_W-1:0]);
            wr(2'd0, cword(1, 1, fr, p, s[1:0], 0, 0));
            repeat (3) @(negedge clk);
            for (int j = 0; j < n; j++) begin
                for (int h = 0; h < 6; h++) begin
                    logic lvl;
                    lvl  = (h < 3) ? ~p : p;
                    pins = 4'($urandom);
                    pins[s] = lvl;
                    @(negedge clk);
                end
            end
            repeat (6) @(negedge clk);
            rd(2'd2, d);
            check(p ? "R7 falling edge count" : "R6 rising edge count", d, exp_cnt(n, c, fr));
            rd(2'd0, d);
            check("R6 R4 pulse hit flag", d[7], exp_flag(n, c));
        end

        finish_run();
    end
endmodule